// File: doc/BRIEF.md
# Infrared Pulse Stream Decoder

This block recovers a plain serial receive line for a UART receiver from an active-low infrared pulse stream. Each short low pulse on the infrared line stands for a data 0. A bit period with no pulse stands for a data 1. The block samples the raw line through a synchroniser, detects falling edges and measures the spacing between them in ticks of a baud-rate enable. That enable runs at sixteen times the bit rate.

After a pulse is accepted, the next pulse is expected one bit period (16 ticks) later. It is accepted anywhere from 4 ticks early to 8 ticks late. A falling edge that arrives before this window opens is treated as noise and gives no output. Every falling edge, accepted or not, restarts the tick counter, so the block follows jitter and small rate errors in the incoming stream. If the window closes with no pulse, the block returns to its idle state. The next falling edge is then accepted as a fresh start. Each accepted pulse drives the recovered line low for one full bit period. The line rests high at all other times, and it stays high while the block is disabled or in reset.

The block does not affect how the downstream UART aligns itself. It only shapes the receive line, and the UART still aligns on its own start bit.

Top module: `ir_pulse_decoder`

## Requirements
- R1: While reset is asserted, and after reset while no falling edge has been seen, `rxd_out` is 1.
- R2: In the idle state, a falling edge on `ir_rx_n` is accepted. `rxd_out` then goes low and stays low for exactly 16 `baud_tick` periods before returning to 1.
- R3: After an accepted pulse, a falling edge that arrives 12 to 24 ticks after the previous falling edge is accepted, and it restarts the 16-tick low period. Spacings of 12 to 15 ticks therefore give a continuous low level.
- R4: A falling edge that arrives 1 to 11 ticks after the previous falling edge, while the window is being tracked, is rejected. It does not pull `rxd_out` low.
- R5: If no falling edge arrives within 24 ticks of the previous one, the block returns to idle. The next falling edge is then accepted, however late it comes.
- R6: Every falling edge seen while enabled restarts the tick count, including a rejected one. Spacing is therefore always measured from the most recent edge.
- R7: While `enable` is 0, `rxd_out` is 1 from the next clock on and all falling edges are ignored. When `enable` returns to 1, the block starts again from idle.
- R8: Only falling edges count. A low level held for any length of time produces a single 16-tick low period.
- R9: `rxd_out` falls on the third rising clock edge after `ir_rx_n` falls. The path is two synchroniser flops plus one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | Single-cycle enable at 16 times the bit rate |
| enable | input | 1 | Decoder enable; 0 forces idle and a high output |
| ir_rx_n | input | 1 | Raw active-low infrared receive line |
| rxd_out | output | 1 | Recovered serial line for the UART receiver, idle high |

## Verification
The first pattern is a pair of pulses, swept over separations of 2 to 30 ticks. It separates three cases: rejection of early edges, acceptance inside the window including both boundaries, and a fresh start after the window has expired. The second pattern is a set of triples whose middle pulse is an early glitch. These tell apart spacing measured from every edge and spacing measured only from accepted edges. The third is a jittered run of spacings, which checks that a continuous low level is held. The remaining patterns are a long held low level and toggling of the enable, including disabling during a low period. Between them they cover edge-versus-level detection and the forced idle state.

// File: rtl/ir_dec_pkg.sv
`timescale 1ns/1ps
package ir_dec_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_TRACK = 1'b1
  } dec_state_e;

  // first tick count at which a following edge is accepted
  function automatic int win_open(input int ovs, input int early);
    return ovs - early;
  endfunction

  // last tick count at which a following edge is accepted
  function automatic int win_close(input int ovs, input int late);
    return ovs + late;
  endfunction

endpackage

// File: rtl/ir_rst_sync.sv
`timescale 1ns/1ps
module ir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ir_in_sync.sv
`timescale 1ns/1ps
module ir_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic fall
);

  // stages 0..STAGES-1 synchronise, stage STAGES holds the previous sample
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  assign pipe_d[0] = raw_n;

  generate
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      assign pipe_d[i] = pipe_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/ir_win_fsm.sv
`timescale 1ns/1ps
module ir_win_fsm
  import ir_dec_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int EARLY      = 4,
  parameter int LATE       = 8,
  parameter int CW         = $clog2(OVERSAMPLE + LATE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          fall,
  output logic          accept,
  output logic          tracking,
  output logic [CW-1:0] cnt
);

  localparam int WIN_LO = win_open(OVERSAMPLE, EARLY);
  localparam int WIN_HI = win_close(OVERSAMPLE, LATE);

  dec_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_window;

  assign in_window = (cnt_q >= CW'(WIN_LO)) && (cnt_q <= CW'(WIN_HI));
  assign accept    = enable && fall && ((state_q == ST_IDLE) || in_window);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!enable) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (fall) begin
      // every edge resynchronises the count; only accepted ones arm tracking
      cnt_d = '0;
      if (accept) begin
        state_d = ST_TRACK;
      end
    end else if (tick && (state_q == ST_TRACK)) begin
      if (cnt_q == CW'(WIN_HI)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign tracking = (state_q == ST_TRACK);
  assign cnt      = cnt_q;

endmodule

// File: rtl/ir_low_shaper.sv
`timescale 1ns/1ps
module ir_low_shaper #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic accept,
  output logic rxd
);

  localparam int RW = $clog2(OVERSAMPLE + 1);

  logic [RW-1:0] remain_q, remain_d;
  logic          rxd_q, rxd_d;

  always_comb begin
    remain_d = remain_q;
    if (!enable) begin
      remain_d = '0;
    end else if (accept) begin
      remain_d = RW'(OVERSAMPLE);
    end else if (tick && (remain_q != '0)) begin
      remain_d = remain_q - 1'b1;
    end
    rxd_d = (remain_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      rxd_q    <= 1'b1;
    end else begin
      remain_q <= remain_d;
      rxd_q    <= rxd_d;
    end
  end

  assign rxd = rxd_q;

endmodule

// File: rtl/ir_pulse_decoder.sv
`timescale 1ns/1ps
module ir_pulse_decoder #(
  parameter int OVERSAMPLE  = 16,
  parameter int EARLY       = 4,
  parameter int LATE        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic enable,
  input  logic ir_rx_n,
  output logic rxd_out
);

  localparam int CW = $clog2(OVERSAMPLE + LATE + 1);

  logic          rst_sync_n;
  logic          edge_fall;
  logic          pulse_accept;
  logic          win_tracking;
  logic [CW-1:0] win_cnt;

  ir_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  ir_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw_n (ir_rx_n),
    .fall  (edge_fall)
  );

  ir_win_fsm #(
    .OVERSAMPLE (OVERSAMPLE),
    .EARLY      (EARLY),
    .LATE       (LATE),
    .CW         (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (baud_tick),
    .enable   (enable),
    .fall     (edge_fall),
    .accept   (pulse_accept),
    .tracking (win_tracking),
    .cnt      (win_cnt)
  );

  ir_low_shaper #(.OVERSAMPLE(OVERSAMPLE)) u_shape (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (baud_tick),
    .enable (enable),
    .accept (pulse_accept),
    .rxd    (rxd_out)
  );

endmodule

// File: rtl/ir_dec_chk.sv
`timescale 1ns/1ps
module ir_dec_chk #(
  parameter int OVERSAMPLE = 16,
  parameter int EARLY      = 4,
  parameter int LATE       = 8,
  parameter int CW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          fall,
  input logic          accept,
  input logic          tracking,
  input logic [CW-1:0] cnt,
  input logic          rxd
);

  localparam int WIN_LO = OVERSAMPLE - EARLY;
  localparam int WIN_HI = OVERSAMPLE + LATE;

  // R7
  disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> rxd);

  // R2
  accept_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rxd);

  // R2
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd) |-> $past(accept));

  // R4
  early_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fall && tracking && (cnt < CW'(WIN_LO)) && rxd) |=> rxd);

  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tracking |-> (cnt <= CW'(WIN_HI)));

  // R6
  resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fall) |=> (cnt == '0));

endmodule

bind ir_pulse_decoder ir_dec_chk #(
  .OVERSAMPLE (OVERSAMPLE),
  .EARLY      (EARLY),
  .LATE       (LATE),
  .CW         (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .enable   (enable),
  .fall     (edge_fall),
  .accept   (pulse_accept),
  .tracking (win_tracking),
  .cnt      (win_cnt),
  .rxd      (rxd_out)
);

// File: tb/ir_pulse_decoder_bench.sv
`timescale 1ns/1ps
module ir_pulse_decoder_bench;

  localparam int OVS    = 16;
  localparam int WLO    = 12;
  localparam int PERIOD = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, baud_tick, enable, ir_rx_n;
  logic rxd_out;

  int    checks, fails;
  int    step_no, last_acc, last_edge;
  logic  prev_ir;
  string cur_req;
  bit    done;

  ir_pulse_decoder u_ir_pulse_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .enable    (enable),
    .ir_rx_n   (ir_rx_n),
    .rxd_out   (rxd_out)
  );

  task automatic report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (step %0d)", req, what, act, exp, step_no);
    end
  endtask

  // low during steps a+1 .. a+16 after the latest accepted edge at step a
  function automatic logic exp_rxd();
    return !(last_acc >= 0 && step_no >= last_acc + 1 && step_no <= last_acc + OVS);
  endfunction

  // one baud tick period; the input changes together with the tick
  task automatic do_step(input logic v);
    bit   acc;
    logic pre;
    @(negedge clk);
    pre = exp_rxd();
    chk(cur_req, rxd_out, pre, "rxd at step start");
    acc = 1'b0;
    if (enable && prev_ir && !v) begin
      if (last_edge < 0 || step_no - last_edge >= WLO) begin
        last_acc = step_no;
        acc      = 1'b1;
      end
      last_edge = step_no;
    end
    prev_ir   = v;
    ir_rx_n   = v;
    baud_tick = 1'b1;
    step_no++;
    for (int k = 1; k < PERIOD; k++) begin
      @(negedge clk);
      baud_tick = 1'b0;
      // R9: high after two edges, low after the third
      if (acc && pre) chk("R9", rxd_out, (k == 3) ? 1'b0 : 1'b1, "latency");
    end
  endtask

  task automatic idle(input int n);
    repeat (n) do_step(1'b1);
  endtask

  // falling edge now, next step count d later
  task automatic pulse_gap(input int d);
    int w;
    w = (d > 3) ? 3 : d - 1;
    repeat (w) do_step(1'b0);
    repeat (d - w) do_step(1'b1);
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk);
    enable = v;
    if (!v) begin
      last_acc  = -1;
      last_edge = -1;
    end
  endtask

  initial begin
    int g1s[3] = '{5, 8, 11};
    int g2s[4] = '{6, 10, 12, 16};
    int jit[8] = '{14, 18, 16, 20, 13, 23, 12, 24};
    done = 1'b0; checks = 0; fails = 0;
    rst_n = 1'b0; enable = 1'b0; baud_tick = 1'b0; ir_rx_n = 1'b1;
    prev_ir = 1'b1; last_acc = -1; last_edge = -1; step_no = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", rxd_out, 1'b1, "in reset");
    rst_n  = 1'b1;
    enable = 1'b1;
    repeat (4) @(negedge clk);
    idle(5);

    cur_req = "R2";
    pulse_gap(40);

    cur_req = "R8";
    repeat (40) do_step(1'b0);
    idle(30);

    // pairs: R4 below the window, R3 inside it, R5 after it closes
    for (int d = 2; d <= 30; d++) begin
      cur_req = (d < WLO) ? "R4" : ((d <= 24) ? "R3" : "R5");
      pulse_gap(d);
      pulse_gap(40);
    end

    // R6: early glitch in the middle restarts the count
    foreach (g1s[i]) begin
      foreach (g2s[j]) begin
        cur_req = "R6";
        pulse_gap(g1s[i]);
        pulse_gap(g2s[j]);
        pulse_gap(40);
      end
    end

    // R3: jittered stream of zeros
    cur_req = "R3";
    foreach (jit[i]) pulse_gap(jit[i]);
    pulse_gap(40);

    // R7: pulses ignored while disabled, fresh start afterwards
    cur_req = "R7";
    set_enable(1'b0);
    pulse_gap(20);
    pulse_gap(20);
    set_enable(1'b1);
    idle(2);
    pulse_gap(40);
    // R7: disabling during a low period forces the line high
    do_step(1'b0); do_step(1'b0); do_step(1'b0);
    idle(3);
    set_enable(1'b0);
    idle(5);
    set_enable(1'b1);
    idle(20);

    report();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

endmodule